// File: doc/BRIEF.md
# Power-Aware Banked Synchronous RAM

This block is a single-port synchronous memory whose depth is divided into several banks, each holding full-width words. The top address bits pick a bank and the lower bits pick a word inside it. Every bank has its own enable. Gating logic raises only the enable of the bank that an access actually needs, so at most one bank draws access power in any cycle.

Beyond the address decode, two kinds of cycle leave every bank idle. The first is a read that would return the word already on the output: a read of the same address as the previous read, with no write to that address in between. The second is a cycle with no request. During a write, only the target bank is enabled and it performs no read. The read output holds its last value through writes, idle cycles and suppressed reads. The sequence of values on the read port is the same as that of an ungated memory.

Requests use a valid/ready pair. The block never applies back-pressure: `req_ready` stays high, and a request is taken in every cycle that `req_valid` is high. The read response has no ready signal. `rd_valid` is high for exactly one cycle, the cycle after each accepted read, and the consumer must capture `rd_data` in that cycle. The per-bank enables are brought out so that their activity can be observed.

Top module: `pbr_banked_ram`

## Requirements
- R1: The read data is the full-width word last written to the requested address. It appears on `rd_data` one clock after the read request, and `rd_valid` is high in that same cycle.
- R2: For each request that is not suppressed, `bank_en` is one-hot. The set bit is at the index given by `req_addr[ADDR_W-1:ADDR_W-SEL_W]`, which is bits 10:8 by default. No two banks are ever enabled in the same cycle.
- R3: A read to the address of the previous read, with no write to that address in between, enables no bank. `rd_data` keeps its value and `rd_valid` still rises in the next cycle. A write to any other address does not end this condition.
- R4: A write never changes `rd_data`. In the cycle after a write, `rd_data` has the same value it had before the write.
- R5: A write enables only the selected bank and performs no read. `rd_valid` is low in the cycle after a write.
- R6: A write to the address of the previous read ends the repeated-read condition. The next read of that address enables its bank and returns the newly written word.
- R7: A cycle with `req_valid` low enables no bank. In the following cycle `rd_data` is unchanged and `rd_valid` is low.
- R8: For any mix of reads, writes and idle cycles, the values on `rd_data` match those of an ungated memory.
- R9: `req_ready` is always high, and every read request produces a `rd_valid` pulse one cycle later.
- R10: While reset is asserted, `rd_data` is zero, `rd_valid` is low and `bank_en` is zero. The first read after reset is never suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request accepted; always high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (11) | Word address; top SEL_W bits select the bank |
| req_wdata | input | DATA_W (36) | Write data |
| rd_valid | output | 1 | Read response valid, one cycle after a read |
| rd_data | output | DATA_W (36) | Read data, held between reads |
| bank_en | output | BANKS (8) | Per-bank enable, for observation of activity |

## Verification
The bound checker watches every cycle for several properties. It checks that at most one bank is enabled, that the enable follows the bank decode, and that repeated reads and idle cycles leave every bank off. It also checks that `rd_data` is stable after writes, suppressed reads and idle cycles, and that `rd_valid` follows each read. Two properties need the directed scenarios and the reference-memory bench instead. The first is that the held data is the correct word, in particular after a write to the held address. The second is that the whole read sequence, and the number of suppressed accesses, agree with an ungated memory.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_READ   = 2'd2,
    OP_REREAD = 2'd3
  } pbr_op_e;
endpackage

// File: rtl/pbr_gate_ctrl.sv
module pbr_gate_ctrl
  import pbr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BANKS  = 8,
  localparam int SEL_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  output pbr_op_e           op,
  output logic [SEL_W-1:0]  sel,
  output logic [BANKS-1:0]  bank_en
);
  logic [ADDR_W-1:0] held_addr;
  logic              held_ok;
  logic              hit;

  assign sel = req_addr[ADDR_W-1 -: SEL_W];
  assign hit = held_ok && (req_addr == held_addr);

  always_comb begin
    if (!req_valid)  op = OP_IDLE;
    else if (req_we) op = OP_WRITE;
    else if (hit)    op = OP_REREAD;
    else             op = OP_READ;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_en
    assign bank_en[b] = ((op == OP_WRITE) || (op == OP_READ)) && (sel == SEL_W'(b));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_addr <= '0;
      held_ok   <= 1'b0;
    end else begin
      case (op)
        OP_READ: begin
          held_addr <= req_addr;
          held_ok   <= 1'b1;
        end
        OP_WRITE: if (hit) held_ok <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pbr_bank.sv
module pbr_bank #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 256,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[off] <= wdata;
  end

  // Output register only loads on an enabled read; writes leave it alone.
  always_ff @(posedge clk) begin
    if (!rst_n)          q <= '0;
    else if (en && !we)  q <= mem[off];
  end
endmodule

// File: rtl/pbr_out_mux.sv
module pbr_out_mux
  import pbr_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int BANKS  = 8,
  localparam int SEL_W = $clog2(BANKS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  pbr_op_e                       op,
  input  logic [SEL_W-1:0]              sel,
  input  logic [BANKS-1:0][DATA_W-1:0]  bank_q,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (op == OP_READ) sel_q <= sel;
      rd_valid <= (op == OP_READ) || (op == OP_REREAD);
    end
  end

  assign rd_data = bank_q[sel_q];
endmodule

// File: rtl/pbr_banked_ram.sv
module pbr_banked_ram
  import pbr_pkg::*;
#(
  parameter int DATA_W     = 36,
  parameter int BANK_DEPTH = 256,
  parameter int BANKS      = 8,
  localparam int OFF_W  = $clog2(BANK_DEPTH),
  localparam int SEL_W  = $clog2(BANKS),
  localparam int ADDR_W = OFF_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [BANKS-1:0]  bank_en
);
  pbr_op_e                      op;
  logic [SEL_W-1:0]             sel;
  logic [BANKS-1:0][DATA_W-1:0] bank_q;

  assign req_ready = 1'b1;

  pbr_gate_ctrl #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .op(op), .sel(sel), .bank_en(bank_en)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    pbr_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(bank_en[b]), .we(req_we),
      .off(req_addr[OFF_W-1:0]), .wdata(req_wdata), .q(bank_q[b])
    );
  end

  pbr_out_mux #(.DATA_W(DATA_W), .BANKS(BANKS)) u_mux (
    .clk(clk), .rst_n(rst_n), .op(op), .sel(sel), .bank_q(bank_q),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/pbr_checker.sv
module pbr_checker #(
  parameter int DATA_W = 36,
  parameter int BANKS  = 8,
  parameter int ADDR_W = 11,
  localparam int SEL_W = $clog2(BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [BANKS-1:0]  bank_en
);
  logic [ADDR_W-1:0] ck_addr;
  logic              ck_ok;
  logic              rep_rd;
  logic [SEL_W-1:0]  ck_sel;

  assign ck_sel = req_addr[ADDR_W-1 -: SEL_W];
  assign rep_rd = req_valid && !req_we && ck_ok && (req_addr == ck_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_addr <= '0;
      ck_ok   <= 1'b0;
    end else if (req_valid && !req_we) begin
      ck_addr <= req_addr;
      ck_ok   <= 1'b1;
    end else if (req_valid && req_we && req_addr == ck_addr) begin
      ck_ok   <= 1'b0;
    end
  end

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en)); // R2
  AST_BANK_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rep_rd) |-> (bank_en == (BANKS'(1) << ck_sel))); // R2
  AST_REREAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rep_rd |-> (bank_en == '0)); // R3
  AST_REREAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rep_rd |=> ($stable(rd_data) && rd_valid)); // R3
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> $stable(rd_data)); // R4
  AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> !rd_valid); // R5
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (bank_en == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rd_data) && !rd_valid)); // R7
  AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rd_valid); // R9
endmodule

bind pbr_banked_ram pbr_checker #(.DATA_W(DATA_W), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data), .bank_en(bank_en)
);

// File: tb/pbr_banked_ram_bench.sv
module pbr_banked_ram_bench;
  localparam int DW = 36;
  localparam int NB = 8;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [NB-1:0] bank_en;

  int checks = 0;
  int errors = 0;
  int sup_model = 0;
  int sup_seen = 0;

  logic [DW-1:0] ref_mem [1 << AW];
  logic [AW-1:0] m_last = '0;
  bit            m_rep = 1'b0;
  logic [DW-1:0] exp_rd = '0;
  logic [31:0]   seed = 32'h1357_9bdf;

  always #10 clk = ~clk;

  pbr_banked_ram u_pbr_banked_ram (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .bank_en(bank_en)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One access, entered and left at a falling edge.
  task automatic acc(input bit v, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    logic [NB-1:0] exp_en;
    bit exp_val;
    exp_en = '0;
    if (v && we) exp_en = NB'(1) << a[AW-1:AW-3];
    else if (v && !(m_rep && a == m_last)) exp_en = NB'(1) << a[AW-1:AW-3];
    if (v && !we && m_rep && a == m_last) sup_model++;
    req_valid = v; req_we = we; req_addr = a; req_wdata = d;
    #2;
    check(bank_en == exp_en, {tag, " bank_en"}, 64'(bank_en), 64'(exp_en));
    check(req_ready == 1'b1, "R9 req_ready", 64'(req_ready), 64'd1);
    if (v && !we && bank_en == '0) sup_seen++;
    exp_val = v && !we;
    if (v && we) begin
      ref_mem[a] = d;
      if (a == m_last) m_rep = 1'b0;
    end else if (v) begin
      exp_rd = ref_mem[a];
      m_last = a;
      m_rep = 1'b1;
    end
    @(posedge clk); #2;
    check(rd_valid == exp_val, {tag, " rd_valid"}, 64'(rd_valid), 64'(exp_val));
    check(rd_data == exp_rd, {tag, " rd_data"}, 64'(rd_data), 64'(exp_rd));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(rd_data == '0, "R10 reset rd_data", 64'(rd_data), 64'd0);
    check(rd_valid == 1'b0, "R10 reset rd_valid", 64'(rd_valid), 64'd0);
    check(bank_en == '0, "R10 reset bank_en", 64'(bank_en), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    m_rep = 1'b0; exp_rd = '0;
  endtask

  task automatic t_basic();
    for (int b = 0; b < NB; b++)
      acc(1, 1, AW'((b << 8) | (b * 5 + 1)), DW'(36'h9_0000_0000 | (b * 36'h111)), "R5 write");
    for (int b = NB - 1; b >= 0; b--)
      acc(1, 0, AW'((b << 8) | (b * 5 + 1)), '0, "R1 R2 read");
    acc(1, 1, 11'h0FF, 36'hF_FFFF_FFFF, "R5 edge write");
    acc(1, 0, 11'h0FF, '0, "R1 edge read");
    acc(1, 1, 11'h7FF, 36'hA_5A5A_5A5A, "R5 top write");
    acc(1, 0, 11'h7FF, '0, "R2 top read");
  endtask

  task automatic t_first_read();
    acc(1, 0, 11'h0FF, '0, "R10 first read");
  endtask

  task automatic t_repeat();
    acc(1, 1, 11'h234, 36'h1_2345_6789, "R3 setup");
    acc(1, 0, 11'h234, '0, "R3 read");
    acc(1, 0, 11'h234, '0, "R3 reread");
    acc(1, 0, 11'h234, '0, "R3 reread2");
    acc(1, 1, 11'h235, 36'h0_0000_0077, "R3 other write");
    acc(1, 0, 11'h234, '0, "R3 reread after other write");
    acc(1, 0, 11'h235, '0, "R3 new addr");
  endtask

  task automatic t_write_hold();
    acc(1, 1, 11'h512, 36'h5_5555_5555, "R4 setup");
    acc(1, 0, 11'h512, '0, "R4 read");
    acc(1, 1, 11'h300, 36'hC_CCCC_CCCC, "R4 write other bank");
    acc(1, 1, 11'h513, 36'h3_3333_3333, "R4 write same bank");
  endtask

  task automatic t_write_clear();
    acc(1, 0, 11'h512, '0, "R6 read");
    acc(1, 1, 11'h512, 36'h6_0606_0606, "R6 overwrite held");
    acc(1, 0, 11'h512, '0, "R6 reread enabled");
    acc(1, 0, 11'h512, '0, "R6 then suppressed");
  endtask

  task automatic t_idle();
    acc(0, 0, 11'h512, '0, "R7 idle");
    acc(0, 1, 11'h100, 36'hD_EAD0_BEEF, "R7 idle with we");
    acc(1, 0, 11'h512, '0, "R7 reread after idle");
  endtask

  task automatic t_mixed();
    int s0;
    int s1;
    for (int i = 0; i < 32; i++)
      acc(1, 1, AW'(((i % 8) << 8) | (i / 8)), DW'(i * 36'h0_0101_0101), "R8 fill");
    s0 = sup_model;
    s1 = sup_seen;
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      seed = seed * 32'd1103515245 + 32'd12345;
      a = AW'((seed[20:18] << 8) | seed[17:16]);
      if (seed[25:23] == 3'd0)      acc(0, 0, a, '0, "R8 idle");
      else if (seed[25:23] <= 3'd2) acc(1, 1, a, {seed[31:0], seed[3:0]}, "R8 write");
      else if (seed[26])            acc(1, 0, m_last, '0, "R8 reread");
      else                          acc(1, 0, a, '0, "R8 read");
    end
    check((sup_seen - s1) == (sup_model - s0), "R3 suppressed count",
          64'(sup_seen - s1), 64'(sup_model - s0));
    check((sup_model - s0) > 0, "R3 suppression exercised", 64'(sup_model - s0), 64'd1);
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_reset();
    t_first_read();
    t_repeat();
    t_write_hold();
    t_write_clear();
    t_idle();
    t_mixed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule